// File: doc/BRIEF.md
# Grouped GPIO Pad Configuration Register Bank

This block holds the per-pad configuration of a GPIO controller whose pads are organised in groups. Each group has room for up to fifteen pads, and each group has its own count of pads that are actually implemented. Software reaches the bank through a simple 32-bit word interface with an address, a write strobe, write data and combinational read data.

Every implemented pad owns two configuration words:

- The pad word holds:
  - the level the pad drives;
  - a 4-bit selector that routes the pad to one of sixteen shared interrupt lines;
  - a read-only view of the pad's synchronised input level.
- The trigger word holds:
  - a 3-bit trigger-type code;
  - a 4-bit inversion field.

The routing selector, the trigger code and a decoded "invert receive data" flag are exported, one set per pad slot, to the interrupt detection logic that sits next to this bank.

Addresses are decoded from a base of 0x4400. Groups are 1024 bytes apart and pads are 8 bytes apart within a group. The pad word is at the even word of each pad and the trigger word is 4 bytes above it. Any access that does not land on an implemented pad is dropped, and it reads back as zero. Pad slots are numbered flat as group × MAX_PADS + pad. Slots past a group's pad count are tied to zero.

Top module: `gpio_pad_bank`

## Requirements
- R1: After reset every writable field is zero: pad_out is all low, every trig_type is 0, every irq_line_sel is 0 and rx_invert is all low.
- R2: The pad word of pad i in group g is at byte address 0x4400 + 1024·g + 8·i, and the trigger word is at that address + 4. A write to bit 1 of the pad word sets pad_out[g·MAX_PADS+i] and no other pad output.
- R3: Bits 31:28 of the pad word are a read/write interrupt-line selector, exported on irq_line_sel[4·k +: 4] for slot k.
- R4: Bits 2:0 of the trigger word hold the trigger code (1 falling, 2 rising, 3 both edges, 4 level), exported on trig_type[3·k +: 3]. Bits 7:4 hold the inversion field, and rx_invert[k] is high exactly when that field equals 4'b0100.
- R5: Bit 0 of the pad word returns pad_in[k] after a synchroniser of SYNC_STAGES flops. With the default of 2, a change on pad_in appears in the read data after the second rising clock edge. Writes to bit 0 have no effect.
- R6: All bits of either word other than those named in R2–R5 read as zero, whatever was written to them.
- R7: An access whose pad index is at or above its group's pad count, or whose group index is at or above NUM_GROUPS, or whose address lies below 0x4400, changes no state and reads as zero. The default pad counts are 15, 12, 13 and 8 for groups 0 to 3.
- R8: An address with bits 1:0 not equal to zero is not a word access. Writing to it changes no state, and reading it returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (16) | Byte address of the access |
| bus_wr_en | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | NUM_GROUPS·MAX_PADS (60) | Raw pad input levels, one per slot |
| pad_out | output | NUM_GROUPS·MAX_PADS (60) | Driven pad levels, one per slot |
| irq_line_sel | output | 4·NUM_GROUPS·MAX_PADS (240) | Interrupt-line selector per slot |
| trig_type | output | 3·NUM_GROUPS·MAX_PADS (180) | Trigger code per slot |
| rx_invert | output | NUM_GROUPS·MAX_PADS (60) | Receive-inversion flag per slot |

## Verification
The hardest cases to reach are the addresses that look legal but are not: the first pad past a group's count, the sixteenth pad position inside a group's 1024-byte window, a group beyond the last one, and a misaligned address that would alias pad 0. The bench writes all ones to each of these addresses and expects zero back. It then re-reads the neighbouring valid words and the exported vectors to show that nothing leaked in. The synchroniser delay is measured by changing one pad input on a falling edge and reading the pad word after one rising edge and again after two.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
   // pad word field positions
   localparam int RX_BIT     = 0;
   localparam int TX_BIT     = 1;
   localparam int SEL_LSB    = 28;
   localparam int SEL_W      = 4;
   // trigger word field positions
   localparam int TRIG_LSB   = 0;
   localparam int TRIG_W     = 3;
   localparam int INV_LSB    = 4;
   localparam int INV_W      = 4;
   localparam logic [INV_W-1:0] INV_RX_CODE = 4'h4;
   // address geometry
   localparam int GROUP_SHIFT = 10;
   localparam int PAD_SHIFT   = 3;
   localparam int CNT_W       = 4;

   typedef enum logic {
      WSEL_PAD  = 1'b0,
      WSEL_TRIG = 1'b1
   } word_sel_e;

   typedef struct packed {
      logic [SEL_W-1:0] sel;
      logic             tx;
   } pad_cfg_t;

   typedef struct packed {
      logic [INV_W-1:0]  inv;
      logic [TRIG_W-1:0] trig;
   } trig_cfg_t;
endpackage

// File: rtl/gpb_sync2.sv
module gpb_sync2 #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpb_sync2: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];

   // the output may only move to a value the input held STAGES edges earlier
   assert_sync_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout) |-> (dout == $past(din, STAGES)));
endmodule

// File: rtl/gpb_addr_decode.sv
module gpb_addr_decode
   import gpb_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int BASE       = 32'h4400,
   parameter int NUM_GROUPS = 4,
   parameter int MAX_PADS   = 15,
   parameter logic [NUM_GROUPS*CNT_W-1:0] PAD_COUNTS = 16'h8DCF,
   localparam int NSLOT  = NUM_GROUPS * MAX_PADS,
   localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output word_sel_e         word,
   output logic [SLOT_W-1:0] slot
);
   localparam int GRP_W = ADDR_W - GROUP_SHIFT;
   localparam int PAD_W = GROUP_SHIFT - PAD_SHIFT;

   if (MAX_PADS > 15 || MAX_PADS < 1) begin : g_bad_pads
      $error("gpb_addr_decode: MAX_PADS must be 1..15");
   end
   if ((BASE % (1 << GROUP_SHIFT)) != 0) begin : g_bad_base
      $error("gpb_addr_decode: BASE must be group aligned");
   end
   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_cnt_chk
      if (int'(PAD_COUNTS[g*CNT_W +: CNT_W]) > MAX_PADS) begin : g_bad_cnt
         $error("gpb_addr_decode: group pad count exceeds MAX_PADS");
      end
   end

   logic [ADDR_W-1:0] off;
   logic [GRP_W-1:0]  grp;
   logic [PAD_W-1:0]  pad;
   logic [CNT_W-1:0]  cnt;
   logic              unused_lo;

   assign off       = addr - ADDR_W'(BASE);
   assign grp       = off[ADDR_W-1:GROUP_SHIFT];
   assign pad       = off[GROUP_SHIFT-1:PAD_SHIFT];
   assign word      = word_sel_e'(off[2]);
   assign unused_lo = ^off[1:0];

   always_comb begin
      cnt = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (grp == GRP_W'(g)) cnt = PAD_COUNTS[g*CNT_W +: CNT_W];
      end
   end

   assign hit  = (addr[1:0] == 2'b00)
              && (addr >= ADDR_W'(BASE))
              && (grp < GRP_W'(NUM_GROUPS))
              && (pad < PAD_W'(cnt));
   assign slot = SLOT_W'(int'(grp) * MAX_PADS + int'(pad));
endmodule

// File: rtl/gpb_pad_slot.sv
module gpb_pad_slot
   import gpb_pkg::*;
#(
   parameter bit VALID       = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_pad,
   input  logic              we_trig,
   input  logic [31:0]       wdata,
   input  logic              pad_in,
   output logic [31:0]       rd_pad,
   output logic [31:0]       rd_trig,
   output logic              pad_out,
   output logic [SEL_W-1:0]  line_sel,
   output logic [TRIG_W-1:0] trig,
   output logic              rx_inv
);
   if (VALID) begin : g_live
      pad_cfg_t  pcfg;
      trig_cfg_t tcfg;
      logic      rx_sync;
      logic      unused_w;

      assign unused_w = ^{wdata[SEL_LSB-1:INV_LSB+INV_W], wdata[TRIG_W]};

      gpb_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (pad_in),
         .dout (rx_sync)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pcfg <= '0;
            tcfg <= '0;
         end else begin
            if (we_pad) begin
               pcfg.sel <= wdata[SEL_LSB +: SEL_W];
               pcfg.tx  <= wdata[TX_BIT];
            end
            if (we_trig) begin
               tcfg.inv  <= wdata[INV_LSB +: INV_W];
               tcfg.trig <= wdata[TRIG_LSB +: TRIG_W];
            end
         end
      end

      always_comb begin
         rd_pad                     = '0;
         rd_pad[SEL_LSB +: SEL_W]   = pcfg.sel;
         rd_pad[TX_BIT]             = pcfg.tx;
         rd_pad[RX_BIT]             = rx_sync;
         rd_trig                    = '0;
         rd_trig[INV_LSB +: INV_W]  = tcfg.inv;
         rd_trig[TRIG_LSB +: TRIG_W] = tcfg.trig;
      end

      assign pad_out  = pcfg.tx;
      assign line_sel = pcfg.sel;
      assign trig     = tcfg.trig;
      assign rx_inv   = (tcfg.inv == INV_RX_CODE);

      // without a pad-word write, the driven level and routing hold
      assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !we_pad |=> $stable({pad_out, line_sel}));
   end else begin : g_hole
      logic unused_hole;
      assign unused_hole = ^{clk, rst_n, we_pad, we_trig, wdata, pad_in};
      assign rd_pad   = '0;
      assign rd_trig  = '0;
      assign pad_out  = 1'b0;
      assign line_sel = '0;
      assign trig     = '0;
      assign rx_inv   = 1'b0;
   end
endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
   import gpb_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int BASE        = 32'h4400,
   parameter int NUM_GROUPS  = 4,
   parameter int MAX_PADS    = 15,
   parameter logic [NUM_GROUPS*CNT_W-1:0] PAD_COUNTS = 16'h8DCF,
   parameter int SYNC_STAGES = 2,
   localparam int NSLOT = NUM_GROUPS * MAX_PADS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr_en,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NSLOT-1:0]    pad_in,
   output logic [NSLOT-1:0]    pad_out,
   output logic [NSLOT*SEL_W-1:0]  irq_line_sel,
   output logic [NSLOT*TRIG_W-1:0] trig_type,
   output logic [NSLOT-1:0]    rx_invert
);
   localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

   if (ADDR_W <= GROUP_SHIFT) begin : g_bad_addr
      $error("gpio_pad_bank: ADDR_W too small for group stride");
   end

   logic              dec_hit;
   word_sel_e         dec_word;
   logic [SLOT_W-1:0] dec_slot;
   logic [NSLOT-1:0]  we_pad;
   logic [NSLOT-1:0]  we_trig;
   logic [31:0]       rd_pad_a  [NSLOT];
   logic [31:0]       rd_trig_a [NSLOT];

   gpb_addr_decode #(
      .ADDR_W    (ADDR_W),
      .BASE      (BASE),
      .NUM_GROUPS(NUM_GROUPS),
      .MAX_PADS  (MAX_PADS),
      .PAD_COUNTS(PAD_COUNTS)
   ) u_dec (
      .addr(bus_addr),
      .hit (dec_hit),
      .word(dec_word),
      .slot(dec_slot)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      for (genvar i = 0; i < MAX_PADS; i++) begin : g_pad
         localparam int K   = g * MAX_PADS + i;
         localparam bit VAL = (i < int'(PAD_COUNTS[g*CNT_W +: CNT_W]));

         assign we_pad[K]  = bus_wr_en && dec_hit && (dec_word == WSEL_PAD)
                          && (dec_slot == SLOT_W'(K));
         assign we_trig[K] = bus_wr_en && dec_hit && (dec_word == WSEL_TRIG)
                          && (dec_slot == SLOT_W'(K));

         gpb_pad_slot #(
            .VALID      (VAL),
            .SYNC_STAGES(SYNC_STAGES)
         ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_pad  (we_pad[K]),
            .we_trig (we_trig[K]),
            .wdata   (bus_wdata),
            .pad_in  (pad_in[K]),
            .rd_pad  (rd_pad_a[K]),
            .rd_trig (rd_trig_a[K]),
            .pad_out (pad_out[K]),
            .line_sel(irq_line_sel[K*SEL_W +: SEL_W]),
            .trig    (trig_type[K*TRIG_W +: TRIG_W]),
            .rx_inv  (rx_invert[K])
         );
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (dec_hit) begin
         bus_rdata = (dec_word == WSEL_TRIG) ? rd_trig_a[dec_slot]
                                             : rd_pad_a[dec_slot];
      end
   end

   // a single write strobe reaches at most one configuration word
   assert_single_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({we_pad, we_trig}));

   // an unmapped write leaves every exported field alone
   assert_unmapped_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && !dec_hit) |=> $stable({pad_out, irq_line_sel, trig_type, rx_invert}));

   // a misaligned write leaves every exported field alone
   assert_misaligned_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && (bus_addr[1:0] != 2'b00))
         |=> $stable({pad_out, irq_line_sel, trig_type, rx_invert}));
endmodule

// File: tb/gpio_pad_bank_bench.sv
`timescale 1ns/1ps
module gpio_pad_bank_bench;
   localparam int NSLOT = 60;
   localparam int NVEC  = 11;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [15:0]        bus_addr = '0;
   logic               bus_wr_en = 1'b0;
   logic [31:0]        bus_wdata = '0;
   logic [31:0]        bus_rdata;
   logic [NSLOT-1:0]   pad_in = '0;
   logic [NSLOT-1:0]   pad_out;
   logic [NSLOT*4-1:0] irq_line_sel;
   logic [NSLOT*3-1:0] trig_type;
   logic [NSLOT-1:0]   rx_invert;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   gpio_pad_bank u_gpio_pad_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr    (bus_addr),
      .bus_wr_en   (bus_wr_en),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .pad_in      (pad_in),
      .pad_out     (pad_out),
      .irq_line_sel(irq_line_sel),
      .trig_type   (trig_type),
      .rx_invert   (rx_invert)
   );

   // {address, write data, expected read-back}
   localparam logic [79:0] VEC [NVEC] = '{
      {16'h4400, 32'hFFFF_FFFF, 32'hF000_0002},  // R2 R3 R5 R6 group0 pad0
      {16'h4404, 32'hFFFF_FFFF, 32'h0000_00F7},  // R4 R6 group0 pad0 trigger word
      {16'h4858, 32'h5000_0002, 32'h5000_0002},  // R2 R3 last pad of group1
      {16'h4860, 32'hFFFF_FFFF, 32'h0000_0000},  // R7 first pad past group1 count
      {16'h4C64, 32'h0000_0043, 32'h0000_0043},  // R4 group2 pad12 trigger word
      {16'h5040, 32'hFFFF_FFFF, 32'h0000_0000},  // R7 group3 pad8 past count
      {16'h5400, 32'hFFFF_FFFF, 32'h0000_0000},  // R7 group beyond last
      {16'h4402, 32'hFFFF_FFFF, 32'h0000_0000},  // R8 misaligned
      {16'h43F8, 32'hFFFF_FFFF, 32'h0000_0000},  // R7 below base
      {16'h4470, 32'h3000_0000, 32'h3000_0000},  // R3 group0 pad14
      {16'h4478, 32'hFFFF_FFFF, 32'h0000_0000}   // R7 sixteenth position
   };

   task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr_en = 1'b1;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   initial begin
      logic [31:0]  rd;
      logic [255:0] e;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 pad_out", 256'(pad_out), '0);
      chk("R1 trig_type", 256'(trig_type), '0);
      chk("R1 irq_line_sel", 256'(irq_line_sel), '0);
      chk("R1 rx_invert", 256'(rx_invert), '0);
      rst_n = 1'b1;
      @(negedge clk);
      bus_read(16'h4400, rd);
      chk("R1 pad word after reset", 256'(rd), '0);

      for (int k = 0; k < NVEC; k++) begin
         bus_write(VEC[k][79:64], VEC[k][63:32]);
         bus_read(VEC[k][79:64], rd);
         chk($sformatf("R2/R3/R4/R6/R7/R8 vector %0d", k), 256'(rd), 256'(VEC[k][31:0]));
      end

      // R8 the misaligned write must not alias pad 0
      bus_read(16'h4400, rd);
      chk("R8 pad0 untouched", 256'(rd), 256'(32'hF000_0002));
      // R2 only the written pads drive
      e = (256'h1 << 0) | (256'h1 << 26);
      chk("R2 pad_out", 256'(pad_out), e);
      // R3 routing export
      e = 256'hF | (256'h3 << 56) | (256'h5 << 104);
      chk("R3 irq_line_sel", 256'(irq_line_sel), e);
      // R4 trigger and inversion export
      e = 256'h7 | (256'h3 << 126);
      chk("R4 trig_type", 256'(trig_type), e);
      chk("R4 rx_invert", 256'(rx_invert), 256'h1 << 42);

      // R5 synchroniser delay on group0 pad5
      @(negedge clk);
      pad_in[5] = 1'b1;
      @(negedge clk);
      bus_read(16'h4428, rd);
      chk("R5 one edge later", 256'(rd[0]), 256'(1'b0));
      @(negedge clk);
      bus_read(16'h4428, rd);
      chk("R5 two edges later", 256'(rd[0]), 256'(1'b1));
      bus_read(16'h4420, rd);
      chk("R5 neighbour pad4", 256'(rd[0]), 256'(1'b0));

      // R2 clearing the drive bit
      bus_write(16'h4400, 32'h0000_0001);
      chk("R2 pad_out cleared", 256'(pad_out), 256'h1 << 26);
      bus_read(16'h4400, rd);
      chk("R5 write to bit0 ignored", 256'(rd), '0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule